// File: doc/BRIEF.md
# Byte Serial-Peripheral Master with Status Flags

This block is a master-only serial peripheral engine. It exposes three byte-wide registers on a small synchronous CPU bus. The registers are control, status and data. Software first sets the clock polarity, clock phase and rate in the control register. A write to the data register then launches an 8-bit exchange, most significant bit first. The byte clocked in on MISO becomes readable at the data address once the exchange ends.

SCK is derived from the system clock through a fixed table of four half-period lengths. While the exchange runs, `busy_o` is high. At the end a completion flag is raised, and the interrupt line follows that flag when interrupts are enabled. A data write that arrives mid-exchange is dropped and recorded as a collision. Status flags are cleared by a two-step handshake: read the status register, then access the data register.

Register map (address on `addr_i`): 0 control, 1 status, 2 data, 3 unused. Control bits: 0 enable, 1 interrupt enable, 2 CPOL, 3 CPHA, 5:4 rate code, 6 and 7 stored only. Status bits: 0 completion, 1 collision, 2 fault (always 0).

Top module: `spi_master_core`

## Requirements
- R1: After reset, reads of control, status and data return 0, and `sck_o`, `busy_o` and `irq_o` are low.
- R2: Rate code (control bits 5:4) 0, 1, 2 and 3 gives an SCK half-period of 1, 2, 8 and 16 clocks (SCK = clk/2, /4, /16, /32). `busy_o` is high for exactly 16 half-periods, starting the cycle after the accepted data write.
- R3: MOSI presents the written byte MSB first, one bit per two half-periods. MISO is sampled at the end of the first half of each bit. After completion, a read of address 2 returns the received byte, first sampled bit in bit 7.
- R4: When idle, SCK equals CPOL (control bit 2). During half-period p (0 to 15) of an exchange, SCK equals CPOL xor CPHA xor (p odd). So with CPHA (bit 3) = 0 the first edge is at mid-bit, and with CPHA = 1 it is at the start of the bit.
- R5: A data write while enable (control bit 0) is clear is ignored: no exchange starts, `busy_o` stays low, and the data read value is unchanged.
- R6: A data write while `busy_o` is high sets the collision flag (status bit 1). The exchange in progress continues with unchanged MOSI bits and received byte.
- R7: Completion sets status bit 0. `irq_o` is high while status bit 0 is set and interrupt enable (control bit 1) is set.
- R8: A status read with any flag set captures those flags. The next data read or enabled data write clears them and drops `irq_o`. A data read without a preceding status read leaves the flags set.
- R9: Writes to the status address change no flag.
- R10: Reset during an exchange aborts it: `busy_o` goes low, SCK returns to idle, control and status read 0.
- R11: If a colliding data write is accepted in the same cycle the exchange completes, both the completion and collision flags are set.
- R12: Control reads back all 8 written bits at address 0. Address 3 reads 0. `rdata_o` is valid in the cycle `re_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with `re_i` |
| miso_i | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| busy_o | output | 1 | Exchange in progress |
| irq_o | output | 1 | Completion interrupt |

## Verification
Completion of an exchange and a colliding data write can fall in the same clock edge. At the fastest rate, the bench issues a data write timed so that the strobe is sampled at the very edge where the sixteenth half-period ends. That edge is where `busy_o` is still high for the last time. The bench then judges the outcome by reading status: both the completion and collision bits must be set. The received byte must still match, and a status-then-data handshake must clear both flags together.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    // control byte, bit 7 down to bit 0
    typedef struct packed {
        logic       hold_b7;
        logic       hold_b6;
        logic [1:0] rate;
        logic       cpha;
        logic       cpol;
        logic       irq_en;
        logic       enable;
    } ctrl_t;

    // status flags, bit 2 down to bit 0
    typedef struct packed {
        logic fault;
        logic coll;
        logic done;
    } flags_t;

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int HALF0 = 1,
    parameter int HALF1 = 2,
    parameter int HALF2 = 8,
    parameter int HALF3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [1:0] rate_i,
    output logic       tick_o
);
    localparam int HMAX_A = (HALF0 > HALF1) ? HALF0 : HALF1;
    localparam int HMAX_B = (HALF2 > HALF3) ? HALF2 : HALF3;
    localparam int HMAX   = (HMAX_A > HMAX_B) ? HMAX_A : HMAX_B;
    localparam int CW     = $clog2(HMAX + 1);

    function automatic int half_sel(input logic [1:0] r);
        case (r)
            2'd0:    return HALF0;
            2'd1:    return HALF1;
            2'd2:    return HALF2;
            default: return HALF3;
        endcase
    endfunction

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] lim_m1;

    always_comb begin
        lim_m1 = CW'(half_sel(rate_i) - 1);
        tick_o = run_i && (cnt_q >= lim_m1);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    slow_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && rate_i != 2'd0) |=> (!tick_o || rate_i == 2'd0));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] tx_i,
    input  logic         tick_i,
    input  logic         miso_i,
    input  logic         cpol_i,
    input  logic         cpha_i,
    output logic         busy_o,
    output logic         sck_o,
    output logic         mosi_o,
    output logic         done_o,
    output logic [W-1:0] rx_o
);
    localparam int PHASES = 2 * W;
    localparam int PW     = $clog2(PHASES);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] phase;
        logic [W-1:0]  tx;
        logic [W-1:0]  rx;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        done_o = 1'b0;
        if (start_i && !st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.phase = '0;
            st_d.tx    = tx_i;
        end else if (st_q.busy && tick_i) begin
            if (!st_q.phase[0]) begin
                st_d.rx    = {st_q.rx[W-2:0], miso_i};
                st_d.phase = st_q.phase + 1'b1;
            end else if (st_q.phase == PW'(PHASES - 1)) begin
                st_d.busy  = 1'b0;
                st_d.phase = '0;
                done_o     = 1'b1;
            end else begin
                st_d.tx    = {st_q.tx[W-2:0], 1'b0};
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
    assign sck_o  = st_q.busy ? (cpol_i ^ cpha_i ^ st_q.phase[0]) : cpol_i;
    assign mosi_o = st_q.tx[W-1];
    assign rx_o   = st_q.rx;

    // R2
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R3
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && mosi_o == $past(tx_i[W-1])));

    // R4
    sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick_i && !start_i && $stable(cpol_i) && $stable(cpha_i))
        |=> (busy_o && $stable(sck_o)));

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
    import spi_master_pkg::*;
#(
    parameter int HALF0 = 1,
    parameter int HALF1 = 2,
    parameter int HALF2 = 8,
    parameter int HALF3 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] addr_i,
    input  logic       we_i,
    input  logic       re_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       busy_o,
    output logic       irq_o
);
    typedef struct packed {
        ctrl_t             ctrl;
        flags_t            flags;
        flags_t            clr_mask;
        logic [BYTE_W-1:0] rx_data;
    } regs_t;

    regs_t r_d, r_q;

    logic              eng_busy, eng_done, tick, start;
    logic [BYTE_W-1:0] eng_rx;
    logic              wr_data, rd_data, wr_stat, rd_stat, wr_ctrl;

    always_comb begin
        wr_ctrl = we_i && (addr_i == ADDR_CTRL);
        wr_stat = we_i && (addr_i == ADDR_STAT);
        rd_stat = re_i && (addr_i == ADDR_STAT);
        wr_data = we_i && (addr_i == ADDR_DATA) && r_q.ctrl.enable;
        rd_data = re_i && (addr_i == ADDR_DATA);
        start   = wr_data && !eng_busy;

        r_d = r_q;
        if (wr_ctrl) r_d.ctrl = ctrl_t'(wdata_i);
        if ((wr_data || rd_data) && (r_q.clr_mask != '0)) begin
            r_d.flags    = r_q.flags & ~r_q.clr_mask;
            r_d.clr_mask = '0;
        end
        if (rd_stat && (r_q.flags != '0)) r_d.clr_mask = r_q.flags;
        if (wr_data && eng_busy) r_d.flags.coll = 1'b1;
        if (eng_done) begin
            r_d.flags.done = 1'b1;
            r_d.clr_mask   = '0;
            r_d.rx_data    = eng_rx;
        end
        r_d.flags.fault = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (re_i) begin
            case (addr_i)
                ADDR_CTRL: rdata_o = r_q.ctrl;
                ADDR_STAT: rdata_o = {5'b0, r_q.flags};
                ADDR_DATA: rdata_o = r_q.rx_data;
                default:   rdata_o = '0;
            endcase
        end
    end

    assign irq_o  = r_q.ctrl.irq_en && r_q.flags.done;
    assign busy_o = eng_busy;

    spi_tick_gen #(
        .HALF0 (HALF0),
        .HALF1 (HALF1),
        .HALF2 (HALF2),
        .HALF3 (HALF3)
    ) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (eng_busy),
        .rate_i (r_q.ctrl.rate),
        .tick_o (tick)
    );

    spi_shift_engine #(
        .W (BYTE_W)
    ) i_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .tx_i    (wdata_i),
        .tick_i  (tick),
        .miso_i  (miso_i),
        .cpol_i  (r_q.ctrl.cpol),
        .cpha_i  (r_q.ctrl.cpha),
        .busy_o  (eng_busy),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o),
        .done_o  (eng_done),
        .rx_o    (eng_rx)
    );

    // R6
    coll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_DATA && r_q.ctrl.enable && busy_o) |=> r_q.flags.coll);

    // R9
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !eng_done) |=> $stable(r_q.flags));

    // R5
    dis_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_DATA && !r_q.ctrl.enable && !busy_o) |=> !busy_o);

    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> r_q.flags.done);

endmodule

// File: tb/test_spi_master_core.sv
module test_spi_master_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       miso = 1'b0;
    logic [7:0] rdata;
    logic       sck, mosi, busy, irq;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    spi_master_core i_spi_master_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .we_i    (we),
        .re_i    (re),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .miso_i  (miso),
        .sck_o   (sck),
        .mosi_o  (mosi),
        .busy_o  (busy),
        .irq_o   (irq)
    );

    // {ctrl, tx byte, miso byte, collision half-period (FF = none)}
    localparam int NV = 6;
    localparam logic [31:0] VEC [NV] = '{
        32'h01_A5_3C_FF,
        32'h17_81_7E_FF,
        32'h2B_C3_96_FF,
        32'h3D_01_80_FF,
        32'h03_F0_0F_0F,
        32'h19_6D_B2_05
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int half_of(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        re = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic run_transfer(input logic [31:0] vec);
        logic [7:0] ctrl, tx, pat, coll, v;
        int h;
        logic cpol, cpha;
        ctrl = vec[31:24]; tx = vec[23:16]; pat = vec[15:8]; coll = vec[7:0];
        h = half_of(ctrl[5:4]); cpol = ctrl[2]; cpha = ctrl[3];
        do_write(2'd0, ctrl);
        check("R4 idle sck", {31'd0, sck}, {31'd0, cpol});
        do_write(2'd2, tx);
        for (int p = 0; p < 16; p++) begin
            check("R2 busy during transfer", {31'd0, busy}, 32'd1);
            check("R4 sck level", {31'd0, sck}, {31'd0, cpol ^ cpha ^ p[0]});
            check("R3 R6 mosi bit", {31'd0, mosi}, {31'd0, tx[7 - p/2]});
            if (!p[0]) miso = pat[7 - p/2];
            if (p == int'(coll)) begin
                we = 1'b1; addr = 2'd2; wdata = ~tx;
            end
            repeat (h) begin
                @(negedge clk);
                we = 1'b0;
            end
        end
        check("R2 busy end", {31'd0, busy}, 32'd0);
        check("R4 sck idle after", {31'd0, sck}, {31'd0, cpol});
        do_read(2'd1, v);
        check("R7 R6 R11 status", {24'd0, v}, {30'd0, coll != 8'hFF, 1'b1});
        check("R7 irq", {31'd0, irq}, {31'd0, ctrl[1]});
        do_read(2'd2, v);
        check("R3 rx byte", {24'd0, v}, {24'd0, pat});
        do_read(2'd1, v);
        check("R8 cleared", {24'd0, v}, 32'd0);
        check("R8 irq low", {31'd0, irq}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 sck", {31'd0, sck}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);
        do_read(2'd0, v); check("R1 ctrl", {24'd0, v}, 32'd0);
        do_read(2'd1, v); check("R1 status", {24'd0, v}, 32'd0);
        do_read(2'd2, v); check("R1 data", {24'd0, v}, 32'd0);

        // R12 readback
        do_write(2'd0, 8'hC4);
        do_read(2'd0, v); check("R12 ctrl readback", {24'd0, v}, 32'hC4);
        do_read(2'd3, v); check("R12 unused addr", {24'd0, v}, 32'd0);
        check("R4 idle at cpol=1", {31'd0, sck}, 32'd1);

        for (int i = 0; i < NV; i++) run_transfer(VEC[i]);

        // R5 disabled write ignored
        do_write(2'd0, 8'h00);
        do_write(2'd2, 8'h55);
        check("R5 no busy", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        check("R5 still idle", {31'd0, busy}, 32'd0);
        do_read(2'd2, v); check("R5 data unchanged", {24'd0, v}, 32'hB2);
        do_read(2'd1, v); check("R5 no flag", {24'd0, v}, 32'd0);

        // R8 data read alone keeps flags; R9 status write
        miso = 1'b1;
        do_write(2'd0, 8'h01);
        do_write(2'd2, 8'h12);
        repeat (16) @(negedge clk);
        check("R2 done after 16 half-periods", {31'd0, busy}, 32'd0);
        do_read(2'd2, v); check("R3 rx all ones", {24'd0, v}, 32'hFF);
        do_read(2'd1, v); check("R8 flag kept without status read", {24'd0, v}, 32'd1);
        do_write(2'd1, 8'h00);
        // previous status read armed a clear; status write must not consume or alter it
        check("R9 status write no effect on irq path", {31'd0, busy}, 32'd0);
        do_read(2'd1, v); check("R9 status unchanged", {24'd0, v}, 32'd1);
        do_write(2'd2, 8'h34);
        do_read(2'd1, v); check("R8 cleared by data write", {24'd0, v}, 32'd0);
        repeat (20) @(negedge clk);

        // R10 reset mid-transfer
        do_read(2'd1, v); do_read(2'd2, v);
        do_write(2'd0, 8'h3D);
        do_write(2'd2, 8'h5A);
        repeat (20) @(negedge clk);
        check("R10 busy before reset", {31'd0, busy}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 busy aborted", {31'd0, busy}, 32'd0);
        check("R10 sck idle", {31'd0, sck}, 32'd0);
        do_read(2'd0, v); check("R10 ctrl zero", {24'd0, v}, 32'd0);
        do_read(2'd1, v); check("R10 status zero", {24'd0, v}, 32'd0);
        repeat (40) @(negedge clk);
        check("R10 stays idle", {31'd0, busy}, 32'd0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule